// File: doc/BRIEF.md
# Ethernet PHY Control and Status Registers

This block holds the two basic management registers of an Ethernet PHY: the control word at address 0 and the capability/status word at address 1. Software, or a serial management front end that has already decoded a frame, reaches them through a plain synchronous port. A write strobe, an address and write data are sampled on the clock edge, and read data is returned combinationally for the current address.

The control word drives the PHY datapath. Its outputs are forced speed and duplex, an autonegotiation enable, a one-cycle negotiation restart pulse, isolate and loopback. When negotiation is enabled, the speed and duplex outputs follow the result that the negotiation engine reports. When negotiation is disabled, they follow the control bits. Power-up strap pins set the reset values of the enable and speed bits. This lets the PHY come up with negotiation held off, so that software can program it before negotiation starts. A later soft reset restores these latched values and does not sample the pins again.

Top module: `phy_ctl_regs`

## Requirements
- R1: The input reset is released through a two-stage synchronizer. On the first clock edge after that release, the strap pins are latched. Control bit 12 (negotiation enable) takes the value of `strap_an_en`. Control bit 13 (speed, 1 = 100 Mb/s) takes `strap_spd` when `strap_spd_valid` is 1, and is 1 otherwise. All other control bits reset to 0.
- R2: Address 1 always reads 0x7800. Bits 15..9 are 0,1,1,1,1,0,0 and bits 8..0 are 0. Writes to address 1 change nothing.
- R3: A control write that sets bit 12 while the enable is currently 0 raises `an_restart` for exactly the one cycle after the write edge.
- R4: A control write with bits 12 and 9 both set raises `an_restart` for the one cycle after the write. During that cycle control bit 9 reads 1, and both return to 0 on the next edge if no new restart is written.
- R5: A control write with bit 12 clear produces no restart pulse, and bit 9 reads 0 after it.
- R6: With the enable at 0, `phy_speed_100` equals control bit 13. With the enable at 1, it equals `an_link_speed`, whatever bit 13 holds.
- R7: With the enable at 0, `phy_full_duplex` equals control bit 8 (1 = full, 0 = half). With the enable at 1, it equals `an_link_full`.
- R8: Control bits 7..0 always read 0, including bit 7 (collision test). Bit 11 (power down) reads back as written and changes no output.
- R9: Control bit 10 drives `phy_isolate` and control bit 14 drives `phy_loopback`.
- R10: A control write with bit 15 set returns every field to the latched power-up values. Bit 15 reads 1 for the one cycle after that write and 0 afterwards, and the strap pins are not sampled again.
- R11: Any address other than 0 and 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_an_en | input | 1 | Power-up value for the negotiation enable bit |
| strap_spd_valid | input | 1 | 1 when the speed strap is present |
| strap_spd | input | 1 | Power-up speed value (1 = 100 Mb/s) |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| an_link_speed | input | 1 | Negotiated speed (1 = 100 Mb/s) |
| an_link_full | input | 1 | Negotiated duplex (1 = full) |
| phy_speed_100 | output | 1 | Active speed |
| phy_full_duplex | output | 1 | Active duplex |
| an_enable | output | 1 | Negotiation enable |
| an_restart | output | 1 | One-cycle negotiation restart pulse |
| phy_isolate | output | 1 | Isolate the MAC-side interface |
| phy_loopback | output | 1 | Block transmission onto the wire |

## Verification
The bench targets the restart paths. If the design compared against the new enable value instead of the old one, the 0-to-1 write would give no pulse or a pulse on every write. If the restart bit were not self-clearing, `an_restart` would stay high. If restart requests were not gated by the enable, a request with negotiation off would leak a pulse. The bench also changes the strap pins before a soft reset: a design that sampled them again would come back with the wrong enable. It drives the speed bit against `an_link_speed` in both enable states, which exposes a mux that ignores the enable. Writes to the status word and to the inert low control bits show up as changed read data.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int REG_W = 16;

  // Control fields, packed so that they land on bits 15..8 of the word
  typedef struct packed {
    logic soft_rst;   // 15
    logic loopback;   // 14
    logic spd100;     // 13
    logic an_en;      // 12
    logic pdown;      // 11
    logic isolate;    // 10
    logic restart;    // 9
    logic full_dup;   // 8
  } ctl_t;

  localparam int B_SOFT_RST = 15;
  localparam int B_SPD      = 13;
  localparam int B_AN_EN    = 12;
  localparam int B_RESTART  = 9;

  function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
    return {c, 8'h00};
  endfunction

  function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
    return ctl_t'(w[REG_W-1:REG_W-8]);
  endfunction
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/phy_strap_latch.sv
module phy_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_an_en,
  input  logic strap_spd_valid,
  input  logic strap_spd,
  output logic done,
  output logic def_an,
  output logic def_spd
);
  logic done_q, an_q, spd_q;
  logic an_d, spd_d, cap_en;

  always_comb begin
    cap_en = !done_q;
    an_d   = strap_an_en;
    spd_d  = strap_spd_valid ? strap_spd : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      an_q   <= 1'b0;
      spd_q  <= 1'b0;
    end else if (cap_en) begin
      done_q <= 1'b1;
      an_q   <= an_d;
      spd_q  <= spd_d;
    end
  end

  // Before capture, the defaults are the live pins, so that the control
  // register can load them on the same edge the latch captures them.
  assign done    = done_q;
  assign def_an  = done_q ? an_q  : an_d;
  assign def_spd = done_q ? spd_q : spd_d;
endmodule

// File: rtl/phy_ctl_core.sv
module phy_ctl_core
  import phy_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loaded,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             def_an,
  input  logic             def_spd,
  output ctl_t             ctl
);
  ctl_t ctl_q, ctl_d, dflt, wr_val;
  logic ctl_en;

  always_comb begin
    dflt          = '0;
    dflt.an_en    = def_an;
    dflt.spd100   = def_spd;

    wr_val         = ctl_unpack(wdata);
    wr_val.soft_rst = 1'b0;
    wr_val.restart  = wdata[B_AN_EN] & (wdata[B_RESTART] | ~ctl_q.an_en);

    ctl_en = !loaded | wr_ctl | ctl_q.soft_rst | ctl_q.restart;

    ctl_d          = ctl_q;
    ctl_d.soft_rst = 1'b0;
    ctl_d.restart  = 1'b0;
    if (!loaded) begin
      ctl_d = dflt;
    end else if (wr_ctl) begin
      if (wdata[B_SOFT_RST]) begin
        ctl_d          = dflt;
        ctl_d.soft_rst = 1'b1;
      end else begin
        ctl_d = wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/phy_stat_word.sv
module phy_stat_word
  import phy_ctl_pkg::*;
#(
  parameter logic [6:0] CAP_BITS = 7'b0111100
) (
  output logic [REG_W-1:0] stat
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i >= REG_W - 7) begin : g_cap
      assign stat[i] = CAP_BITS[i-(REG_W-7)];
    end else begin : g_zero
      assign stat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/phy_mode_sel.sv
module phy_mode_sel
  import phy_ctl_pkg::*;
(
  input  ctl_t ctl,
  input  logic an_link_speed,
  input  logic an_link_full,
  output logic phy_speed_100,
  output logic phy_full_duplex
);
  always_comb begin
    if (ctl.an_en) begin
      phy_speed_100   = an_link_speed;
      phy_full_duplex = an_link_full;
    end else begin
      phy_speed_100   = ctl.spd100;
      phy_full_duplex = ctl.full_dup;
    end
  end
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int         ADDR_W    = 5,
  parameter int         CTL_ADDR  = 0,
  parameter int         STAT_ADDR = 1,
  parameter logic [6:0] CAP_BITS  = 7'b0111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_an_en,
  input  logic              strap_spd_valid,
  input  logic              strap_spd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              an_link_speed,
  input  logic              an_link_full,
  output logic              phy_speed_100,
  output logic              phy_full_duplex,
  output logic              an_enable,
  output logic              an_restart,
  output logic              phy_isolate,
  output logic              phy_loopback
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic rst_int_n, loaded, def_an, def_spd, wr_ctl;
  ctl_t ctl;
  logic [REG_W-1:0] stat;

  phy_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  phy_strap_latch u_strap (
    .clk(clk), .rst_n(rst_int_n),
    .strap_an_en(strap_an_en), .strap_spd_valid(strap_spd_valid), .strap_spd(strap_spd),
    .done(loaded), .def_an(def_an), .def_spd(def_spd)
  );

  assign wr_ctl = reg_wr && (reg_addr == A_CTL);

  phy_ctl_core u_core (
    .clk(clk), .rst_n(rst_int_n), .loaded(loaded), .wr_ctl(wr_ctl),
    .wdata(reg_wdata), .def_an(def_an), .def_spd(def_spd), .ctl(ctl)
  );

  phy_stat_word #(.CAP_BITS(CAP_BITS)) u_stat (.stat(stat));

  phy_mode_sel u_mode (
    .ctl(ctl), .an_link_speed(an_link_speed), .an_link_full(an_link_full),
    .phy_speed_100(phy_speed_100), .phy_full_duplex(phy_full_duplex)
  );

  always_comb begin
    if (reg_addr == A_CTL)       reg_rdata = ctl_pack(ctl);
    else if (reg_addr == A_STAT) reg_rdata = stat;
    else                         reg_rdata = '0;
  end

  assign an_enable    = ctl.an_en;
  assign an_restart   = ctl.restart;
  assign phy_isolate  = ctl.isolate;
  assign phy_loopback = ctl.loopback;
endmodule

// File: rtl/phy_ctl_regs_chk.sv
module phy_ctl_regs_chk #(
  parameter int         ADDR_W    = 5,
  parameter int         CTL_ADDR  = 0,
  parameter int         STAT_ADDR = 1,
  parameter logic [6:0] CAP_BITS  = 7'b0111100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loaded,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              an_link_speed,
  input logic              an_link_full,
  input logic              phy_speed_100,
  input logic              phy_full_duplex,
  input logic              an_enable,
  input logic              an_restart,
  input logic              phy_isolate,
  input logic              phy_loopback
);
  logic wr_c;
  assign wr_c = loaded && reg_wr && (reg_addr == ADDR_W'(CTL_ADDR));

  assert_enable_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !reg_wdata[15] && reg_wdata[12] && !an_enable) |=> an_restart);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart && !wr_c) |=> !an_restart);

  assert_no_restart_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !reg_wdata[12]) |=> !an_restart);

  assert_speed_an_R6: assert property (@(posedge clk) disable iff (!rst_n)
    an_enable |-> (phy_speed_100 == an_link_speed));

  assert_speed_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !reg_wdata[15] && !reg_wdata[12]) |=> (phy_speed_100 == $past(reg_wdata[13])));

  assert_duplex_an_R7: assert property (@(posedge clk) disable iff (!rst_n)
    an_enable |-> (phy_full_duplex == an_link_full));

  assert_status_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_ADDR)) |-> (reg_rdata == {CAP_BITS, 9'b0}));

  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTL_ADDR)) |-> (reg_rdata[7:0] == 8'h00));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && reg_wdata[15]) |=> (!phy_loopback && !phy_isolate && !an_restart));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(CTL_ADDR) && reg_addr != ADDR_W'(STAT_ADDR)) |-> (reg_rdata == 16'h0000));
endmodule

bind phy_ctl_regs phy_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .STAT_ADDR(STAT_ADDR), .CAP_BITS(CAP_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .loaded(loaded),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .an_link_speed(an_link_speed), .an_link_full(an_link_full),
  .phy_speed_100(phy_speed_100), .phy_full_duplex(phy_full_duplex),
  .an_enable(an_enable), .an_restart(an_restart),
  .phy_isolate(phy_isolate), .phy_loopback(phy_loopback)
);

// File: tb/sim_phy_ctl_regs.sv
`timescale 1ns/1ps
module sim_phy_ctl_regs;
  logic clk = 1'b0;
  logic rst_n;
  logic strap_an_en, strap_spd_valid, strap_spd;
  logic reg_wr;
  logic [4:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic an_link_speed, an_link_full;
  logic phy_speed_100, phy_full_duplex, an_enable, an_restart, phy_isolate, phy_loopback;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  phy_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .strap_an_en(strap_an_en), .strap_spd_valid(strap_spd_valid), .strap_spd(strap_spd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .an_link_speed(an_link_speed), .an_link_full(an_link_full),
    .phy_speed_100(phy_speed_100), .phy_full_duplex(phy_full_duplex),
    .an_enable(an_enable), .an_restart(an_restart),
    .phy_isolate(phy_isolate), .phy_loopback(phy_loopback)
  );

  // ---------------- behavioural reference model ----------------
  int sync_cnt;
  bit loaded, d_an, d_spd;
  bit m_rst, m_lb, m_spd, m_an, m_pd, m_iso, m_rsp, m_dup;

  task automatic load_defaults();
    m_rst = 0; m_lb = 0; m_spd = d_spd; m_an = d_an;
    m_pd = 0; m_iso = 0; m_rsp = 0; m_dup = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0; loaded = 0; d_an = 0; d_spd = 0;
      m_rst = 0; m_lb = 0; m_spd = 0; m_an = 0; m_pd = 0; m_iso = 0; m_rsp = 0; m_dup = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else if (!loaded) begin
      loaded = 1;
      d_an   = strap_an_en;
      d_spd  = strap_spd_valid ? strap_spd : 1'b1;
      load_defaults();
    end else if (reg_wr && reg_addr == 5'd0) begin
      if (reg_wdata[15]) begin
        load_defaults();
        m_rst = 1;
      end else begin
        bit was_on;
        was_on = m_an;
        m_rst = 0;
        m_lb  = reg_wdata[14]; m_spd = reg_wdata[13]; m_an  = reg_wdata[12];
        m_pd  = reg_wdata[11]; m_iso = reg_wdata[10]; m_dup = reg_wdata[8];
        m_rsp = reg_wdata[12] && (reg_wdata[9] || !was_on);
      end
    end else begin
      m_rst = 0;
      m_rsp = 0;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    if (a == 5'd0) return {m_rst, m_lb, m_spd, m_an, m_pd, m_iso, m_rsp, m_dup, 8'h00};
    if (a == 5'd1) return 16'h7800;
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1/R2/R11", "rdata model", reg_rdata, exp_rd(reg_addr));
      chk("R3/R4", "an_restart model", {15'd0, an_restart}, {15'd0, m_rsp});
      chk("R1", "an_enable model", {15'd0, an_enable}, {15'd0, m_an});
      chk("R6", "speed model", {15'd0, phy_speed_100}, {15'd0, m_an ? an_link_speed : m_spd});
      chk("R7", "duplex model", {15'd0, phy_full_duplex}, {15'd0, m_an ? an_link_full : m_dup});
      chk("R9", "isolate model", {15'd0, phy_isolate}, {15'd0, m_iso});
      chk("R9", "loopback model", {15'd0, phy_loopback}, {15'd0, m_lb});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = 16'h0;
    @(negedge clk);   // first cycle after the write edge
  endtask

  task automatic set_addr(input logic [4:0] a);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit an, input bit sv, input bit sp);
    @(posedge clk); #1;
    rst_n = 0; strap_an_en = an; strap_spd_valid = sv; strap_spd = sp;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; strap_an_en = 0; strap_spd_valid = 1; strap_spd = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; an_link_speed = 1; an_link_full = 1;

    // R1: straps an=0, speed strap present = 0
    do_reset(0, 1, 0);
    chk("R1", "ctl after reset", reg_rdata, 16'h0000);
    chk("R1", "an_enable after reset", {15'd0, an_enable}, 16'h0000);

    // R6/R7 forced, R5 no pulse
    wr(0, 16'h2100);
    chk("R6", "forced speed", {15'd0, phy_speed_100}, 16'h0001);
    chk("R7", "forced full duplex", {15'd0, phy_full_duplex}, 16'h0001);
    chk("R5", "no restart when off", {15'd0, an_restart}, 16'h0000);

    // R3: enable 0 -> 1
    an_link_speed = 0; an_link_full = 0;
    wr(0, 16'h1000);
    chk("R3", "restart on enable rise", {15'd0, an_restart}, 16'h0001);
    chk("R4", "bit9 during pulse", {15'd0, reg_rdata[9]}, 16'h0001);
    @(negedge clk);
    chk("R3", "restart pulse cleared", {15'd0, an_restart}, 16'h0000);
    chk("R6", "speed follows negotiation", {15'd0, phy_speed_100}, 16'h0000);
    chk("R7", "duplex follows negotiation", {15'd0, phy_full_duplex}, 16'h0000);

    // R4: explicit restart with enable held; speed bit ignored
    wr(0, 16'h3300);
    chk("R4", "explicit restart", {15'd0, an_restart}, 16'h0001);
    chk("R6", "speed bit ignored while enabled", {15'd0, phy_speed_100}, 16'h0000);
    @(negedge clk);
    chk("R4", "restart bit self-clears", reg_rdata, 16'h3100);

    // R5: restart with enable off
    wr(0, 16'h0200);
    chk("R5", "restart ignored when off", {15'd0, an_restart}, 16'h0000);
    chk("R5", "bit9 reads 0", reg_rdata, 16'h0000);

    // R8/R9: power down, isolate, low bits
    wr(0, 16'h0CFF);
    chk("R8", "low bits dropped, pdown kept", reg_rdata, 16'h0C00);
    chk("R9", "isolate on", {15'd0, phy_isolate}, 16'h0001);
    chk("R8", "pdown no effect on loopback", {15'd0, phy_loopback}, 16'h0000);
    wr(0, 16'h4000);
    chk("R9", "loopback on", {15'd0, phy_loopback}, 16'h0001);
    chk("R9", "isolate off", {15'd0, phy_isolate}, 16'h0000);

    // R2: status word and writes to it
    set_addr(1);
    chk("R2", "status word", reg_rdata, 16'h7800);
    wr(1, 16'hFFFF);
    chk("R2", "status after write", reg_rdata, 16'h7800);
    set_addr(0);
    chk("R2", "status write left ctl", reg_rdata, 16'h4000);

    // R11: unmapped address
    set_addr(5);
    chk("R11", "unmapped read", reg_rdata, 16'h0000);
    set_addr(0);

    // R10: soft reset; straps changed beforehand must not be resampled
    wr(0, 16'h4D00);
    strap_an_en = 1; strap_spd_valid = 0;
    wr(0, 16'hC000);
    chk("R10", "soft reset flag and defaults", reg_rdata, 16'h8000);
    chk("R10", "loopback cleared", {15'd0, phy_loopback}, 16'h0000);
    @(negedge clk);
    chk("R10", "soft reset self-clears", reg_rdata, 16'h0000);
    chk("R10", "enable not resampled", {15'd0, an_enable}, 16'h0000);

    // R1: hard reset with enable strap set, speed strap absent
    do_reset(1, 0, 0);
    chk("R1", "ctl with an strap", reg_rdata, 16'h3000);
    chk("R1", "an_enable from strap", {15'd0, an_enable}, 16'h0001);

    // R3: with enable already 1, a plain write keeping it 1 gives no pulse
    wr(0, 16'h1000);
    chk("R3", "no pulse without rise", {15'd0, an_restart}, 16'h0000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule